// File: doc/BRIEF.md
# Edge-Pass Lockout Debouncer

This block cleans one bouncy, asynchronous input bit for use inside a clocked design. The raw level is first carried through a chain of flip-flops so that it can be used safely in the clock domain. A small two-state controller then acts on that settled level. While it is armed, it copies any difference between the synchronized level and the clean output to the output on the next clock. That same step starts a lockout counter. During lockout the output is frozen for a fixed number of clocks, whatever the input does. Then the controller re-arms.

Unlike a wait-for-stability filter, the first edge gets through with only the synchronizer delay. The bounce that follows is absorbed by the lockout. The lockout length must be set longer than the worst bounce the input can show. A level change that happens during lockout is not dropped. It is applied in the first armed cycle. Optional single-cycle strobes mark each rising and falling edge of the clean output.

Top module: `bounce_lock_top`

## Requirements
- R1: While `rst` is high, `cleanOut` follows the synchronized input level and both strobes are low. After `rst` falls, with the input still at the level it held during reset, no strobe fires and `cleanOut` does not change.
- R2: With the controller armed and the output settled, a change of `rawIn` launched just after clock edge k shows on `cleanOut` just after edge k + SYNC_STAGES + 1.
- R3: After every change of `cleanOut`, the output holds its value for at least HOLD_CYCLES further clocks. Two output changes are therefore never closer than HOLD_CYCLES + 1 clocks, and the lockout count never goes past HOLD_CYCLES - 1.
- R4: If the synchronized level differs from `cleanOut` when lockout ends, the output takes that level exactly HOLD_CYCLES + 1 clocks after the previous output change.
- R5: A burst of glitches that starts with a transition, ends at the new level and lasts less than HOLD_CYCLES clocks produces exactly one output edge.
- R6: `riseStrobe` (`fallStrobe`) is high for exactly the one cycle in which `cleanOut` has just gone from 0 to 1 (1 to 0). The two strobes are never high together.
- R7: The clean output, the strobes and the lockout timing match, cycle for cycle, a behavioural model of the synchronizer delay, the armed and lockout states and the counter, under every stimulus applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rawIn | input | 1 | Bouncy input, asynchronous to `clk` |
| cleanOut | output | 1 | Debounced level |
| riseStrobe | output | 1 | One-cycle pulse on a rising edge of `cleanOut` |
| fallStrobe | output | 1 | One-cycle pulse on a falling edge of `cleanOut` |

## Verification
The bench applies six kinds of input. A reset with the input held high shows that no false edge appears. A single clean transition measures the latency. A glitch burst that ends at the new level must give a single edge. A burst that ends back at the old level must give a second edge exactly when the lockout expires, which shows that changes made during lockout are not lost. Slow square waves then exercise repeated arm and lockout cycles. A reference model written with a queue and integers is compared against every output on every clock, so any timing offset in the synchronizer or counter shows up.

// File: rtl/bounce_lock_pkg.sv
package bounce_lock_pkg;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_LOCK  = 1'b1
  } lockState_t;

  typedef struct packed {
    logic takeEdge;   // copy synchronized level to output
    logic cntClear;   // restart the lockout counter
    logic cntRun;     // advance the lockout counter
  } lockStrobes_t;

endpackage

// File: rtl/bounce_sync_chain.sv
module bounce_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] stageReg;

  // Plain shift chain; no reset so the settled level survives reset.
  always_ff @(posedge clk) begin
    stageReg <= {stageReg[DEPTH-2:0], asyncIn};
  end

  assign syncOut = stageReg[DEPTH-1];
endmodule

// File: rtl/bounce_lock_datapath.sv
module bounce_lock_datapath
  import bounce_lock_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter bit EMIT_PULSES = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         syncLevel,
  input  lockStrobes_t strobes,
  output logic         changeSeen,
  output logic         holdDone,
  output logic         cleanOut,
  output logic         riseStrobe,
  output logic         fallStrobe
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic             outReg;

  // Lockout counter: cleared on an edge, saturates at its last value.
  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
    end else if (strobes.cntClear) begin
      holdCnt <= '0;
    end else if (strobes.cntRun && (holdCnt != CNT_LAST)) begin
      holdCnt <= holdCnt + CNT_W'(1);
    end
  end

  // Output level: tracks the input during reset so no false edge appears.
  always_ff @(posedge clk) begin
    if (rst) begin
      outReg <= syncLevel;
    end else if (strobes.takeEdge) begin
      outReg <= syncLevel;
    end
  end

  assign changeSeen = (syncLevel != outReg);
  assign holdDone   = (holdCnt == CNT_LAST);
  assign cleanOut   = outReg;

  generate
    if (EMIT_PULSES) begin : g_pulses
      logic riseReg, fallReg;
      always_ff @(posedge clk) begin
        if (rst) begin
          riseReg <= 1'b0;
          fallReg <= 1'b0;
        end else begin
          riseReg <= strobes.takeEdge &  syncLevel;
          fallReg <= strobes.takeEdge & ~syncLevel;
        end
      end
      assign riseStrobe = riseReg;
      assign fallStrobe = fallReg;
    end else begin : g_noPulses
      assign riseStrobe = 1'b0;
      assign fallStrobe = 1'b0;
    end
  endgenerate

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    holdCnt <= CNT_LAST);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(riseStrobe && fallStrobe));

  assert_rise_match_R6: assert property (@(posedge clk) disable iff (rst)
    riseStrobe |-> (cleanOut && !$past(cleanOut)));

  assert_fall_match_R6: assert property (@(posedge clk) disable iff (rst)
    fallStrobe |-> (!cleanOut && $past(cleanOut)));
endmodule

// File: rtl/bounce_lock_ctrl.sv
module bounce_lock_ctrl
  import bounce_lock_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         changeSeen,
  input  logic         holdDone,
  output lockStrobes_t strobes,
  output logic         lockActive
);
  lockState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_ARMED: begin
        if (changeSeen) begin
          strobes.takeEdge = 1'b1;
          strobes.cntClear = 1'b1;
          stateNext        = ST_LOCK;
        end
      end
      ST_LOCK: begin
        strobes.cntRun = 1'b1;
        if (holdDone) stateNext = ST_ARMED;
      end
      default: stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ARMED;
    else     state <= stateNext;
  end

  assign lockActive = (state == ST_LOCK);

  assert_no_edge_in_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK) |-> !strobes.takeEdge);
endmodule

// File: rtl/bounce_lock_top.sv
module bounce_lock_top
  import bounce_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 16,
  parameter bit EMIT_PULSES = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic cleanOut,
  output logic riseStrobe,
  output logic fallStrobe
);
  logic         syncLevel;
  logic         changeSeen;
  logic         holdDone;
  logic         lockActive;
  lockStrobes_t strobes;

  bounce_sync_chain #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .asyncIn (rawIn),
    .syncOut (syncLevel)
  );

  bounce_lock_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .changeSeen (changeSeen),
    .holdDone   (holdDone),
    .strobes    (strobes),
    .lockActive (lockActive)
  );

  bounce_lock_datapath #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .EMIT_PULSES (EMIT_PULSES)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .syncLevel  (syncLevel),
    .strobes    (strobes),
    .changeSeen (changeSeen),
    .holdDone   (holdDone),
    .cleanOut   (cleanOut),
    .riseStrobe (riseStrobe),
    .fallStrobe (fallStrobe)
  );

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (rst)
    lockActive |=> $stable(cleanOut));

  assert_rearm_take_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(lockActive) && changeSeen) |=> (cleanOut != $past(cleanOut)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!riseStrobe && !fallStrobe));
endmodule

// File: tb/test_bounce_lock_top.sv
`timescale 1ns/1ps
module test_bounce_lock_top;
  localparam int STAGES = 2;
  localparam int HOLD   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rawIn = 1'b1;
  logic cleanOut, riseStrobe, fallStrobe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bounce_lock_top #(.SYNC_STAGES(STAGES), .HOLD_CYCLES(HOLD)) i_bounce_lock_top (
    .clk(clk), .rst(rst), .rawIn(rawIn),
    .cleanOut(cleanOut), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe)
  );

  // Behavioural reference model
  bit q[$];
  bit mOut, mRise, mFall, mLock;
  int mCnt;

  initial begin
    for (int i = 0; i < STAGES; i++) q.push_back(1'b1);
  end

  always @(posedge clk) begin
    bit s;
    cyc++;
    s = q[0];
    if (rst) begin
      mOut = s; mLock = 0; mCnt = 0; mRise = 0; mFall = 0;
    end else begin
      mRise = 0; mFall = 0;
      if (!mLock) begin
        if (s != mOut) begin
          mOut = s; mRise = s; mFall = !s; mLock = 1; mCnt = 0;
        end
      end else begin
        if (mCnt == HOLD - 1) mLock = 0;
        else mCnt++;
      end
    end
    void'(q.pop_front());
    q.push_back(rawIn);
  end

  // Edge bookkeeping from the ports
  int riseCount = 0, fallCount = 0;
  int lastEdgeCyc = -1000, prevEdgeCyc = -1000;
  bit prevOut = 1'b1;

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (cleanOut !== mOut || riseStrobe !== mRise || fallStrobe !== mFall) begin
        errors++;
        $display("FAIL R7 cyc %0d: out/rise/fall actual %b%b%b expected %b%b%b",
                 cyc, cleanOut, riseStrobe, fallStrobe, mOut, mRise, mFall);
      end
      if (riseStrobe) riseCount++;
      if (fallStrobe) fallCount++;
      if (cleanOut !== prevOut) begin
        prevEdgeCyc = lastEdgeCyc;
        lastEdgeCyc = cyc;
        checks++;
        if (lastEdgeCyc - prevEdgeCyc < HOLD + 1) begin
          errors++;
          $display("FAIL R3 edge spacing actual %0d expected >= %0d",
                   lastEdgeCyc - prevEdgeCyc, HOLD + 1);
        end
      end
      prevOut = cleanOut;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int n);
    rawIn = v;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    int fe, re;
    // R1: reset with input high
    repeat (6) @(posedge clk);
    #1;
    rst = 1'b0;
    riseCount = 0; fallCount = 0;
    repeat (5) begin @(posedge clk); #1; end
    check("R1 cleanOut after reset", cleanOut, 1);
    check("R1 strobes after reset", riseCount + fallCount, 0);

    // R2: single clean falling transition latency
    rawIn = 1'b0;
    lat = 0;
    while (cleanOut == 1'b1 && lat < 50) begin
      @(posedge clk); #1; lat++;
    end
    check("R2 latency", lat, STAGES + 1);
    drive(1'b0, HOLD + 10);

    // R5: burst ending at new level, shorter than lockout
    riseCount = 0; fallCount = 0;
    drive(1'b1, 1); drive(1'b0, 2); drive(1'b1, 1); drive(1'b0, 1);
    drive(1'b1, HOLD + 10);
    check("R5 rises in burst", riseCount, 1);
    check("R5 falls in burst", fallCount, 0);
    check("R5 final level", cleanOut, 1);

    // R4: burst ending at old level; second edge at lockout end
    riseCount = 0; fallCount = 0;
    drive(1'b0, 1); drive(1'b1, 1); drive(1'b0, 2); drive(1'b1, HOLD + 10);
    check("R4 falls", fallCount, 1);
    check("R4 rises", riseCount, 1);
    check("R4 edge spacing", lastEdgeCyc - prevEdgeCyc, HOLD + 1);
    check("R4 final level", cleanOut, 1);

    // R6 and R3: slow square wave, clean edges each period
    riseCount = 0; fallCount = 0;
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, HOLD + 4);
      drive(1'b1, HOLD + 4);
    end
    check("R6 rise strobes", riseCount, 6);
    check("R6 fall strobes", fallCount, 6);

    // R3: fast toggling held far longer than lockout, edges spaced by lockout
    fe = 0; re = 0;
    for (int k = 0; k < 40; k++) drive(k[0], 3);
    drive(1'b1, HOLD + 10);
    check("R3 settled level", cleanOut, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule